// File: doc/BRIEF.md
# Modified/Invalid Coherent L1 Line Controller

This block runs the coherence protocol for a small direct-mapped first-level cache. Each line has one of two stable conditions: invalid, or modified with full read and write rights. The core sends loads, instruction fetches, stores and atomics through a request queue. If the line is already modified, the request completes at once as a hit. If it is not, the controller asks the home directory for exclusive ownership and completes the request when the data arrives.

The directory talks back to the controller on two in-order channels. One carries forwarded messages: ownership requests from other caches, writeback acknowledgements and refusals, and invalidations. The other carries data fills. A modified line that must be displaced by a different address is written back with its data. A copy of that data stays in a per-set transaction buffer, so the controller can still give the data to another cache that asks for ownership while the writeback is pending. Every set that is waiting on the network blocks all new core requests to that set.

Top module: `mi_l1_ctl`

## Requirements
- R1: Request kind 0 (load) and 1 (fetch) read the line. Kind 2 (store) and 3 (atomic) write `req_wdata` to the line. Every completion returns, on `done_data`, the line value that results from the request.
- R2: A request to an invalid set is accepted. A GETX (`net_req_kind` 0) for the request address appears on `net_req_valid` in the ISSUE_LAT-th cycle after the accepting edge, counting that edge as the first.
- R3: While a set is waiting on the network, `req_ready` stays low for requests that map to that set. This holds for a fill, a writeback, or a refused writeback.
- R4: A data response to a set waiting for a fill is accepted. It completes the pending request with `done_hit` = 0, one edge after acceptance. A load returns the response data. A store returns its own write data and keeps it as the line value.
- R5: A request to a modified line with a matching tag completes with `done_hit` = 1 one edge after acceptance.
- R6: A request that finds its set modified under another tag is not accepted. Instead, a PUTX (`net_req_kind` 1) is sent with the old address and data. An eviction notice is sent with the old address. The set then waits for a writeback acknowledgement (forward kind 1), after which the held request is accepted as a miss.
- R7: A forwarded GETX (forward kind 0) to a modified line is handled as follows. After RSP_LAT cycles, the line data goes out on the response channel to `fwd_src`. An eviction notice is sent, and the line becomes invalid, so the next load to it misses.
- R8: While a writeback is pending, a forwarded GETX is answered with the buffered data. If it comes before the directory's verdict, the set then waits for the refusal (forward kind 2) before it becomes invalid. If it comes after a refusal, the set becomes invalid at once.
- R9: When a forwarded message is valid, `rsp_ready` and `req_ready` are low. When a data response is valid, `req_ready` is low. At most one event is taken per cycle.
- R10: An invalidation (forward kind 3) to a modified line sends an eviction notice, sends no data response, and leaves the line invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request present |
| req_kind | input | 2 | 0 load, 1 fetch, 2 store, 3 atomic |
| req_addr | input | ADDR_W | Line address of the request |
| req_wdata | input | DATA_W | Write data for store or atomic |
| req_ready | output | 1 | Request popped this cycle |
| done_valid | output | 1 | Core request completed |
| done_hit | output | 1 | Completion was a hit |
| done_data | output | DATA_W | Line value after the request |
| evict_valid | output | 1 | Eviction notice to the core |
| evict_addr | output | ADDR_W | Address of the evicted line |
| fwd_valid | input | 1 | Forwarded message present |
| fwd_kind | input | 2 | 0 GETX, 1 writeback ack, 2 writeback nack, 3 invalidate |
| fwd_addr | input | ADDR_W | Forwarded message address |
| fwd_src | input | ID_W | Requesting cache identifier |
| fwd_ready | output | 1 | Forwarded message consumed |
| rsp_valid | input | 1 | Data response present |
| rsp_addr | input | ADDR_W | Data response address |
| rsp_data | input | DATA_W | Data response payload |
| rsp_ready | output | 1 | Data response consumed |
| net_req_valid | output | 1 | Outgoing request |
| net_req_kind | output | 1 | 0 GETX, 1 PUTX |
| net_req_addr | output | ADDR_W | Outgoing request address |
| net_req_data | output | DATA_W | Writeback data for PUTX |
| net_rsp_valid | output | 1 | Outgoing data response |
| net_rsp_addr | output | ADDR_W | Outgoing response address |
| net_rsp_data | output | DATA_W | Outgoing response data |
| net_rsp_dest | output | ID_W | Outgoing response destination |

## Verification
Loads, fetches, stores and atomics are each sent both to an invalid line and to a modified line. Comparing the two separates the hit path from the fill path, and shows whether the store data or the fill data is the value that survives. Eviction is driven through all three writeback orderings: acknowledged, forwarded request before a refusal, and refusal before a forwarded request. A wrong order shows up as stale data on the network, or as a core request being accepted too early. Simultaneous traffic on all three inputs shows whether arbitration is correct. An invalidation that is followed by silence on the response channel separates it from a forwarded ownership request.

// File: rtl/mi_pkg.sv
package mi_pkg;
    typedef enum logic [2:0] {
        LS_I   = 3'd0,
        LS_M   = 3'd1,
        LS_IS  = 3'd2,
        LS_IM  = 3'd3,
        LS_MI  = 3'd4,
        LS_MII = 3'd5,
        LS_II  = 3'd6
    } line_state_e;

    localparam logic [1:0] FK_GETX  = 2'd0;
    localparam logic [1:0] FK_ACK   = 2'd1;
    localparam logic [1:0] FK_NACK  = 2'd2;
    localparam logic [1:0] FK_INV   = 2'd3;

    localparam logic NK_GETX = 1'b0;
    localparam logic NK_PUTX = 1'b1;

    function automatic logic is_waiting(line_state_e s);
        return (s != LS_I) && (s != LS_M);
    endfunction
endpackage

// File: rtl/mi_req_decode.sv
module mi_req_decode (
    input  logic [1:0] kind,
    output logic       writes
);
    // loads and fetches read; stores and atomics both write
    always_comb writes = kind[1];
endmodule

// File: rtl/mi_delay_pipe.sv
module mi_delay_pipe #(
    parameter int LAT = 2,
    parameter int W   = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_v,
    input  logic [W-1:0] in_d,
    output logic         out_v,
    output logic [W-1:0] out_d
);
    logic [LAT-1:0]        v_q;
    logic [LAT-1:0][W-1:0] d_q;

    for (genvar g = 0; g < LAT; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    v_q[g] <= 1'b0;
                    d_q[g] <= '0;
                end else begin
                    v_q[g] <= in_v;
                    d_q[g] <= in_d;
                end
            end
        end else begin : g_tail
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    v_q[g] <= 1'b0;
                    d_q[g] <= '0;
                end else begin
                    v_q[g] <= v_q[g-1];
                    d_q[g] <= d_q[g-1];
                end
            end
        end
    end

    assign out_v = v_q[LAT-1];
    assign out_d = d_q[LAT-1];
endmodule

// File: rtl/mi_l1_ctl.sv
module mi_l1_ctl
    import mi_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int SETS         = 4,
    parameter int DATA_W       = 16,
    parameter int ID_W         = 2,
    parameter int ISSUE_LAT    = 2,
    parameter int RSP_LAT      = 12,
    parameter int EVICT_NOTIFY = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              done_valid,
    output logic              done_hit,
    output logic [DATA_W-1:0] done_data,
    output logic              evict_valid,
    output logic [ADDR_W-1:0] evict_addr,
    input  logic              fwd_valid,
    input  logic [1:0]        fwd_kind,
    input  logic [ADDR_W-1:0] fwd_addr,
    input  logic [ID_W-1:0]   fwd_src,
    output logic              fwd_ready,
    input  logic              rsp_valid,
    input  logic [ADDR_W-1:0] rsp_addr,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              rsp_ready,
    output logic              net_req_valid,
    output logic              net_req_kind,
    output logic [ADDR_W-1:0] net_req_addr,
    output logic [DATA_W-1:0] net_req_data,
    output logic              net_rsp_valid,
    output logic [ADDR_W-1:0] net_rsp_addr,
    output logic [DATA_W-1:0] net_rsp_data,
    output logic [ID_W-1:0]   net_rsp_dest
);
    localparam int IDX_W  = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int TAG_W  = ADDR_W - IDX_W;
    localparam int NREQ_W = 1 + ADDR_W + DATA_W;
    localparam int NRSP_W = ID_W + ADDR_W + DATA_W;

    typedef struct packed {
        line_state_e [SETS-1:0]             st;
        logic        [SETS-1:0][TAG_W-1:0]  tag;
        logic        [SETS-1:0][DATA_W-1:0] dat;
        logic        [SETS-1:0][DATA_W-1:0] tbe;
        logic                               done_v;
        logic                               done_h;
        logic        [DATA_W-1:0]           done_d;
        logic                               ev_v;
        logic        [ADDR_W-1:0]           ev_a;
    } ctl_s;

    ctl_s q, d;

    logic              nreq_v, nrsp_v;
    logic [NREQ_W-1:0] nreq_in, nreq_out;
    logic [NRSP_W-1:0] nrsp_in, nrsp_out;
    logic              r_writes;

    mi_req_decode u_dec (.kind(req_kind), .writes(r_writes));

    wire [IDX_W-1:0] r_idx = req_addr[IDX_W-1:0];
    wire [TAG_W-1:0] r_tag = req_addr[ADDR_W-1:IDX_W];
    wire [IDX_W-1:0] f_idx = fwd_addr[IDX_W-1:0];
    wire [TAG_W-1:0] f_tag = fwd_addr[ADDR_W-1:IDX_W];
    wire [IDX_W-1:0] s_idx = rsp_addr[IDX_W-1:0];
    wire [TAG_W-1:0] s_tag = rsp_addr[ADDR_W-1:IDX_W];

    wire r_busy   = is_waiting(q.st[r_idx]);
    wire r_victim = (q.st[r_idx] == LS_M) && (q.tag[r_idx] != r_tag);
    wire f_match  = q.tag[f_idx] == f_tag;
    wire s_match  = q.tag[s_idx] == s_tag;

    always_comb begin
        d         = q;
        d.done_v  = 1'b0;
        d.done_h  = 1'b0;
        d.ev_v    = 1'b0;
        nreq_v    = 1'b0;
        nreq_in   = '0;
        nrsp_v    = 1'b0;
        nrsp_in   = '0;
        fwd_ready = 1'b1;
        rsp_ready = !fwd_valid;
        req_ready = !fwd_valid && !rsp_valid && !r_busy && !r_victim;

        if (fwd_valid) begin
            if (f_match) begin
                unique case (fwd_kind)
                    FK_GETX: begin
                        if (q.st[f_idx] == LS_M) begin
                            nrsp_v         = 1'b1;
                            nrsp_in        = {fwd_src, fwd_addr, q.dat[f_idx]};
                            d.ev_v         = (EVICT_NOTIFY != 0);
                            d.ev_a         = fwd_addr;
                            d.st[f_idx]    = LS_I;
                        end else if (q.st[f_idx] == LS_MI || q.st[f_idx] == LS_MII) begin
                            nrsp_v         = 1'b1;
                            nrsp_in        = {fwd_src, fwd_addr, q.tbe[f_idx]};
                            d.st[f_idx]    = (q.st[f_idx] == LS_MI) ? LS_II : LS_I;
                        end
                    end
                    FK_ACK: begin
                        if (q.st[f_idx] == LS_MI) d.st[f_idx] = LS_I;
                    end
                    FK_NACK: begin
                        if (q.st[f_idx] == LS_MI)      d.st[f_idx] = LS_MII;
                        else if (q.st[f_idx] == LS_II) d.st[f_idx] = LS_I;
                    end
                    default: begin
                        if (q.st[f_idx] == LS_M) begin
                            d.ev_v      = (EVICT_NOTIFY != 0);
                            d.ev_a      = fwd_addr;
                            d.st[f_idx] = LS_I;
                        end
                    end
                endcase
            end
        end else if (rsp_valid) begin
            if (s_match && q.st[s_idx] == LS_IS) begin
                d.dat[s_idx] = rsp_data;
                d.done_v     = 1'b1;
                d.done_d     = rsp_data;
                d.st[s_idx]  = LS_M;
            end else if (s_match && q.st[s_idx] == LS_IM) begin
                d.dat[s_idx] = q.tbe[s_idx];
                d.done_v     = 1'b1;
                d.done_d     = q.tbe[s_idx];
                d.st[s_idx]  = LS_M;
            end
        end else if (req_valid && !r_busy) begin
            if (r_victim) begin
                d.tbe[r_idx] = q.dat[r_idx];
                nreq_v       = 1'b1;
                nreq_in      = {NK_PUTX, q.tag[r_idx], r_idx, q.dat[r_idx]};
                d.ev_v       = (EVICT_NOTIFY != 0);
                d.ev_a       = {q.tag[r_idx], r_idx};
                d.st[r_idx]  = LS_MI;
            end else if (q.st[r_idx] == LS_M) begin
                d.done_v = 1'b1;
                d.done_h = 1'b1;
                if (r_writes) begin
                    d.dat[r_idx] = req_wdata;
                    d.done_d     = req_wdata;
                end else begin
                    d.done_d     = q.dat[r_idx];
                end
            end else begin
                d.tag[r_idx] = r_tag;
                nreq_v       = 1'b1;
                nreq_in      = {NK_GETX, req_addr, {DATA_W{1'b0}}};
                if (r_writes) begin
                    d.tbe[r_idx] = req_wdata;
                    d.st[r_idx]  = LS_IM;
                end else begin
                    d.st[r_idx]  = LS_IS;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= {SETS{LS_I}};
        end else begin
            q <= d;
        end
    end

    mi_delay_pipe #(.LAT(ISSUE_LAT), .W(NREQ_W)) u_req_pipe (
        .clk(clk), .rst_n(rst_n), .in_v(nreq_v), .in_d(nreq_in),
        .out_v(net_req_valid), .out_d(nreq_out));

    mi_delay_pipe #(.LAT(RSP_LAT), .W(NRSP_W)) u_rsp_pipe (
        .clk(clk), .rst_n(rst_n), .in_v(nrsp_v), .in_d(nrsp_in),
        .out_v(net_rsp_valid), .out_d(nrsp_out));

    assign {net_req_kind, net_req_addr, net_req_data} = nreq_out;
    assign {net_rsp_dest, net_rsp_addr, net_rsp_data} = nrsp_out;
    assign done_valid  = q.done_v;
    assign done_hit    = q.done_h;
    assign done_data   = q.done_d;
    assign evict_valid = q.ev_v;
    assign evict_addr  = q.ev_a;
endmodule

// File: rtl/mi_l1_ctl_chk.sv
module mi_l1_ctl_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic fwd_valid,
    input logic rsp_valid,
    input logic rsp_ready,
    input logic done_valid,
    input logic done_hit,
    input logic evict_valid
);
    a_r9_fwd_wins: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> (!rsp_ready && !req_ready));

    a_r9_rsp_beats_core: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    a_r5_hit_from_core: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_hit) |-> $past(req_valid && req_ready));

    a_r4_fill_from_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !done_hit) |-> $past(rsp_valid && rsp_ready));

    a_r6_evict_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        evict_valid |-> $past(fwd_valid || (req_valid && !req_ready)));
endmodule

bind mi_l1_ctl mi_l1_ctl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .fwd_valid(fwd_valid), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .done_valid(done_valid), .done_hit(done_hit), .evict_valid(evict_valid));

// File: tb/sim_mi_l1_ctl.sv
module sim_mi_l1_ctl;
    localparam int ISSUE_LAT = 2;
    localparam int RSP_LAT   = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [7:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready;
    logic        done_valid, done_hit;
    logic [15:0] done_data;
    logic        evict_valid;
    logic [7:0]  evict_addr;
    logic        fwd_valid = 1'b0;
    logic [1:0]  fwd_kind = '0;
    logic [7:0]  fwd_addr = '0;
    logic [1:0]  fwd_src = '0;
    logic        fwd_ready;
    logic        rsp_valid = 1'b0;
    logic [7:0]  rsp_addr = '0;
    logic [15:0] rsp_data = '0;
    logic        rsp_ready;
    logic        net_req_valid, net_req_kind;
    logic [7:0]  net_req_addr;
    logic [15:0] net_req_data;
    logic        net_rsp_valid;
    logic [7:0]  net_rsp_addr;
    logic [15:0] net_rsp_data;
    logic [1:0]  net_rsp_dest;

    mi_l1_ctl #(.ISSUE_LAT(ISSUE_LAT), .RSP_LAT(RSP_LAT)) u0 (.*);

    always #5 clk = ~clk;

    int checks = 0, errors = 0, cyc = 0;
    int n_req = 0, n_rsp = 0, n_done = 0, n_ev = 0;
    int rq_cyc, rs_cyc, dn_cyc, ev_cyc;
    logic        rq_kind, dn_hit;
    logic [7:0]  rq_addr, rs_addr, ev_a;
    logic [15:0] rq_data, rs_data, dn_data;
    logic [1:0]  rs_dest;
    bit finished = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (net_req_valid) begin
            n_req <= n_req + 1; rq_cyc <= cyc; rq_kind <= net_req_kind;
            rq_addr <= net_req_addr; rq_data <= net_req_data;
        end
        if (net_rsp_valid) begin
            n_rsp <= n_rsp + 1; rs_cyc <= cyc; rs_addr <= net_rsp_addr;
            rs_data <= net_rsp_data; rs_dest <= net_rsp_dest;
        end
        if (done_valid) begin
            n_done <= n_done + 1; dn_cyc <= cyc; dn_hit <= done_hit; dn_data <= done_data;
        end
        if (evict_valid) begin
            n_ev <= n_ev + 1; ev_cyc <= cyc; ev_a <= evict_addr;
        end
    end

    task automatic chk(input string rq, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic core_acc(input logic [1:0] k, input logic [7:0] a,
                            input logic [15:0] w, output int e);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = w;
        #1;
        for (int i = 0; i < 100 && !req_ready; i++) begin
            @(negedge clk); #1;
        end
        e = cyc + 1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic send_fwd(input logic [1:0] k, input logic [7:0] a,
                            input logic [1:0] src, output int e);
        @(negedge clk);
        fwd_valid = 1'b1; fwd_kind = k; fwd_addr = a; fwd_src = src;
        e = cyc + 1;
        @(negedge clk);
        fwd_valid = 1'b0;
    endtask

    task automatic send_rsp(input logic [7:0] a, input logic [15:0] dv, output int e);
        @(negedge clk);
        rsp_valid = 1'b1; rsp_addr = a; rsp_data = dv;
        e = cyc + 1;
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    task automatic probe_stall(input logic [7:0] a, input string rq);
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'd2; req_addr = a; req_wdata = 16'hDEAD;
        #1;
        chk(rq, "req_ready while set waits", int'(req_ready), 0);
        req_valid = 1'b0;
    endtask

    task automatic expect_net_req(input int e, input logic k, input logic [7:0] a,
                                  input logic [15:0] dv, input int n0, input string rq);
        wait_to(e + ISSUE_LAT + 1);
        chk(rq, "net req count", n_req, n0 + 1);
        chk(rq, "net req cycle", rq_cyc, e + ISSUE_LAT - 1);
        chk(rq, "net req kind", int'(rq_kind), int'(k));
        chk(rq, "net req addr", int'(rq_addr), int'(a));
        if (k) chk(rq, "net req data", int'(rq_data), int'(dv));
    endtask

    task automatic expect_done(input int e, input logic h, input logic [15:0] dv, input string rq);
        wait_to(e + 1);
        chk(rq, "done cycle", dn_cyc, e);
        chk(rq, "done hit", int'(dn_hit), int'(h));
        chk(rq, "done data", int'(dn_data), int'(dv));
    endtask

    task automatic expect_net_rsp(input int e, input logic [7:0] a, input logic [15:0] dv,
                                  input logic [1:0] dst, input string rq);
        wait_to(e + RSP_LAT + 1);
        chk(rq, "net rsp cycle", rs_cyc, e + RSP_LAT - 1);
        chk(rq, "net rsp addr", int'(rs_addr), int'(a));
        chk(rq, "net rsp data", int'(rs_data), int'(dv));
        chk(rq, "net rsp dest", int'(rs_dest), int'(dst));
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R2", "net_req_valid after reset", int'(net_req_valid), 0);
        chk("R1", "done_valid after reset", int'(done_valid), 0);
        chk("R6", "evict_valid after reset", int'(evict_valid), 0);
    endtask

    task automatic t_load_miss;
        int e, n0;
        n0 = n_req;
        core_acc(2'd0, 8'h10, 16'h0, e);
        expect_net_req(e, 1'b0, 8'h10, 16'h0, n0, "R2");
        probe_stall(8'h10, "R3");
        send_rsp(8'h10, 16'hA5A5, e);
        expect_done(e, 1'b0, 16'hA5A5, "R4");
    endtask

    task automatic t_hits;
        int e;
        core_acc(2'd0, 8'h10, 16'h0, e);
        expect_done(e, 1'b1, 16'hA5A5, "R5");
        core_acc(2'd1, 8'h10, 16'h0, e);
        expect_done(e, 1'b1, 16'hA5A5, "R1");
        core_acc(2'd3, 8'h10, 16'h1234, e);
        expect_done(e, 1'b1, 16'h1234, "R1");
        core_acc(2'd0, 8'h10, 16'h0, e);
        expect_done(e, 1'b1, 16'h1234, "R5");
    endtask

    task automatic t_replace_ack;
        int e, n0, ne;
        n0 = n_req; ne = n_ev;
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'd0; req_addr = 8'h20;
        e = cyc + 1;
        @(negedge clk); #1;
        chk("R6", "held request not popped", int'(req_ready), 0);
        req_valid = 1'b0;
        expect_net_req(e, 1'b1, 8'h10, 16'h1234, n0, "R6");
        chk("R6", "evict count", n_ev, ne + 1);
        chk("R6", "evict addr", int'(ev_a), 8'h10);
        chk("R6", "evict cycle", ev_cyc, e);
        send_fwd(2'd1, 8'h10, 2'd0, e);
        n0 = n_req;
        core_acc(2'd0, 8'h20, 16'h0, e);
        expect_net_req(e, 1'b0, 8'h20, 16'h0, n0, "R6");
        send_rsp(8'h20, 16'h0BEE, e);
        expect_done(e, 1'b0, 16'h0BEE, "R6");
    endtask

    task automatic t_fwd_getx;
        int e, n0;
        send_fwd(2'd0, 8'h20, 2'd2, e);
        wait_to(e + 1);
        chk("R7", "evict addr", int'(ev_a), 8'h20);
        chk("R7", "evict cycle", ev_cyc, e);
        expect_net_rsp(e, 8'h20, 16'h0BEE, 2'd2, "R7");
        n0 = n_req;
        core_acc(2'd0, 8'h20, 16'h0, e);
        expect_net_req(e, 1'b0, 8'h20, 16'h0, n0, "R7");
        send_rsp(8'h20, 16'h3333, e);
        expect_done(e, 1'b0, 16'h3333, "R7");
    endtask

    task automatic t_getx_in_mi;
        int e, n0;
        n0 = n_req;
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'd0; req_addr = 8'h30;
        e = cyc + 1;
        @(negedge clk);
        req_valid = 1'b0;
        expect_net_req(e, 1'b1, 8'h20, 16'h3333, n0, "R8");
        send_fwd(2'd0, 8'h20, 2'd1, e);
        probe_stall(8'h30, "R3");
        expect_net_rsp(e, 8'h20, 16'h3333, 2'd1, "R8");
        probe_stall(8'h30, "R8");
        send_fwd(2'd2, 8'h20, 2'd0, e);
        n0 = n_req;
        core_acc(2'd0, 8'h30, 16'h0, e);
        expect_net_req(e, 1'b0, 8'h30, 16'h0, n0, "R8");
        send_rsp(8'h30, 16'h4444, e);
        expect_done(e, 1'b0, 16'h4444, "R8");
    endtask

    task automatic t_nack_then_getx;
        int e, n0;
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'd2; req_addr = 8'h40; req_wdata = 16'h7777;
        @(negedge clk);
        req_valid = 1'b0;
        send_fwd(2'd2, 8'h30, 2'd0, e);
        probe_stall(8'h40, "R8");
        send_fwd(2'd0, 8'h30, 2'd3, e);
        expect_net_rsp(e, 8'h30, 16'h4444, 2'd3, "R8");
        n0 = n_req;
        core_acc(2'd2, 8'h40, 16'h7777, e);
        expect_net_req(e, 1'b0, 8'h40, 16'h0, n0, "R8");
        send_rsp(8'h40, 16'h5555, e);
        expect_done(e, 1'b0, 16'h7777, "R4");
        core_acc(2'd0, 8'h40, 16'h0, e);
        expect_done(e, 1'b1, 16'h7777, "R4");
    endtask

    task automatic t_priority;
        @(negedge clk);
        fwd_valid = 1'b1; fwd_kind = 2'd1; fwd_addr = 8'h81;
        rsp_valid = 1'b1; rsp_addr = 8'h81; rsp_data = 16'h0;
        req_valid = 1'b1; req_kind = 2'd0; req_addr = 8'h41;
        #1;
        chk("R9", "fwd_ready", int'(fwd_ready), 1);
        chk("R9", "rsp_ready under fwd", int'(rsp_ready), 0);
        chk("R9", "req_ready under fwd", int'(req_ready), 0);
        fwd_valid = 1'b0;
        #1;
        chk("R9", "rsp_ready alone", int'(rsp_ready), 1);
        chk("R9", "req_ready under rsp", int'(req_ready), 0);
        rsp_valid = 1'b0; req_valid = 1'b0;
    endtask

    task automatic t_inv;
        int e, n0, nr;
        nr = n_rsp;
        send_fwd(2'd3, 8'h40, 2'd1, e);
        wait_to(e + 1);
        chk("R10", "evict addr", int'(ev_a), 8'h40);
        chk("R10", "evict cycle", ev_cyc, e);
        wait_to(e + RSP_LAT + 2);
        chk("R10", "no data response", n_rsp, nr);
        n0 = n_req;
        core_acc(2'd0, 8'h40, 16'h0, e);
        expect_net_req(e, 1'b0, 8'h40, 16'h0, n0, "R10");
        send_rsp(8'h40, 16'h0, e);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_load_miss;
        t_hits;
        t_replace_ack;
        t_fwd_getx;
        t_getx_in_mi;
        t_nack_then_getx;
        t_priority;
        t_inv;
        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule